// File: doc/BRIEF.md
# Cache line construction buffer

The block sits between a narrow external memory port and a 256-bit first-level cache array. When a miss needs a fill, the requester asks for a line slot. The block grants a free slot and returns its index. The memory then sends the line's chunks in order, each tagged with that slot index. Each chunk is placed at the next position in the slot. Once every chunk has arrived, the slot offers the whole line to the cache write port in a single transfer, which carries the line address and the data together. The slot is freed after the cache accepts that transfer.

Validity is tracked per byte, so the core may read and write the buffer while a line is still filling. A core store sets its bytes valid. A chunk that arrives later fills only the bytes that are still invalid, so the buffer always holds the newest copy. A core read is answered from the buffer only when every requested byte is valid. Otherwise the read misses and the core retries. A chunk flagged non-cacheable skips the slots and is forwarded on its own.

Top module: `line_build_buf`

## Requirements
- R1: A fill request is granted in the same cycle when at least one slot is free. The grant names the first free slot found by searching upward (wrapping at 4) from the slot after the last one granted; after reset the search starts at slot 0. While all 4 slots are occupied, `fill_gnt_o` stays 0.
- R2: The k-th chunk sent to a slot (counting from 0) lands in line bits k*64 to k*64+63. A line is complete after its 4th chunk.
- R3: `cw_valid_o` rises in the cycle after a slot's last chunk arrives, and never earlier. It then carries the slot's line address and all 256 bits. When several slots are complete, the lowest-numbered one is offered first.
- R4: While `cw_valid_o` is high and `cw_ready_i` is low, the offered line address and data stay unchanged. The slot is freed at the accepting edge and can be granted again from the next cycle.
- R5: A core write hits a line that is still filling. It updates the bytes selected by `core_be_i` and marks them valid: bit i selects byte i of the 64-bit word `core_word_i`, and word w occupies line bits w*64 and up. Chunks never overwrite valid bytes. When a store and a chunk reach the same byte in the same cycle, the store wins.
- R6: A core read of a held line whose enabled bytes are all valid gets a response in the next cycle with `rsp_valid_o`=1 and `rsp_hit_o`=1. The response data carries the buffer bytes in the enabled positions and zero elsewhere. Hit and data reflect the state before the clock edge of the request.
- R7: A core read that targets a line not held, or that enables any byte not yet valid, responds with `rsp_hit_o`=0 and zero data.
- R8: A core write is refused, with `rsp_hit_o`=0 and the line content unchanged, when its line is not held or when the slot is complete and waiting for the cache.
- R9: A memory chunk with `mem_nc_i`=1 appears on `nc_data_o`, with `nc_valid_o`=1, in the next cycle and touches no slot.
- R10: After reset all slots are free and `cw_valid_o`, `rsp_valid_o` and `nc_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_req_i | input | 1 | Request a slot for a line fill |
| fill_line_i | input | 27 | Line address to fill |
| fill_gnt_o | output | 1 | Slot granted this cycle |
| fill_slot_o | output | 2 | Index of granted slot |
| mem_valid_i | input | 1 | Memory chunk present |
| mem_nc_i | input | 1 | Chunk is non-cacheable |
| mem_slot_i | input | 2 | Destination slot of the chunk |
| mem_data_i | input | 64 | Chunk data |
| nc_valid_o | output | 1 | Non-cacheable chunk forwarded |
| nc_data_o | output | 64 | Forwarded non-cacheable data |
| core_req_i | input | 1 | Core access request |
| core_we_i | input | 1 | 1 = write, 0 = read |
| core_line_i | input | 27 | Core line address |
| core_word_i | input | 2 | 64-bit word within line |
| core_be_i | input | 8 | Byte enables within word |
| core_wdata_i | input | 64 | Core write data |
| rsp_valid_o | output | 1 | Core response present |
| rsp_hit_o | output | 1 | Access served by buffer |
| rsp_rdata_o | output | 64 | Read data, enabled bytes only |
| cw_valid_o | output | 1 | Cache line write offered |
| cw_ready_i | input | 1 | Cache accepts the line write |
| cw_line_o | output | 27 | Line address of cache write |
| cw_data_o | output | 256 | Full line data |

## Verification
Two activities can fall in the same cycle: a core store and a memory chunk aimed at the same 64-bit word, and a core access against a slot that is being offered to or accepted by the cache. The bench forces the first collision directly, with a half-word store issued together with the chunk. It then reads the word back and checks that the stored bytes kept the core value while the others took the chunk. The random phase keeps producing both collisions. A bench model, updated from the pre-edge state, predicts every grant, response and cache transfer, and each cycle is compared against that prediction.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_FILL = 2'd1,
    SL_FULL = 2'd2
  } slot_state_e;
endpackage

// File: rtl/lcb_alloc.sv
module lcb_alloc #(
  parameter int N    = 4,
  parameter int IW   = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  free_i,
  input  logic          req_i,
  output logic          gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] rr_q;
  logic          found;
  int unsigned   j;

  // first free slot at or after the round-robin pointer
  always_comb begin
    found = 1'b0;
    idx_o = '0;
    j     = 0;
    for (int k = 0; k < N; k++) begin
      j = (int'(rr_q) + k) % N;
      if (!found && free_i[j]) begin
        found = 1'b1;
        idx_o = IW'(j);
      end
    end
  end

  assign gnt_o = req_i && found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rr_q <= '0;
    else if (gnt_o) rr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + IW'(1);
  end

  a_r1_gnt_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> free_i[idx_o]);
endmodule

// File: rtl/lcb_slot.sv
module lcb_slot import lcb_pkg::*; #(
  parameter int LINE_W = 256,
  parameter int BEAT_W = 64,
  parameter int LA_W   = 27,
  localparam int LINE_B = LINE_W / 8,
  localparam int BEAT_B = BEAT_W / 8,
  localparam int BEATS  = LINE_W / BEAT_W,
  localparam int BI_W   = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int CW     = $clog2(BEATS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [LA_W-1:0]   alloc_line_i,
  input  logic              beat_i,
  input  logic [BEAT_W-1:0] beat_data_i,
  input  logic              cwr_i,
  input  logic [LINE_B-1:0] cwr_mask_i,
  input  logic [LINE_W-1:0] cwr_data_i,
  input  logic              release_i,
  output slot_state_e       state_o,
  output logic [LA_W-1:0]   line_o,
  output logic [LINE_W-1:0] data_o,
  output logic [LINE_B-1:0] valid_o
);
  slot_state_e       state_q;
  logic [CW-1:0]     cnt_q;
  logic [LA_W-1:0]   line_q;
  logic [LINE_W-1:0] data_q;
  logic [LINE_B-1:0] valid_q, core_b, fill_b, beat_win;
  logic [LINE_W-1:0] beat_line;

  assign beat_line = {BEATS{beat_data_i}};
  assign beat_win  = LINE_B'({BEAT_B{1'b1}}) << (BEAT_B * int'(cnt_q[BI_W-1:0]));

  // core store wins over a chunk on the same byte
  always_comb begin
    core_b = (cwr_i && state_q == SL_FILL) ? cwr_mask_i : '0;
    fill_b = (beat_i && state_q == SL_FILL) ? (beat_win & ~valid_q & ~core_b) : '0;
  end

  for (genvar b = 0; b < LINE_B; b++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (core_b[b])      data_q[b*8 +: 8] <= cwr_data_i[b*8 +: 8];
      else if (fill_b[b]) data_q[b*8 +: 8] <= beat_line[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SL_FREE;
      cnt_q   <= '0;
      line_q  <= '0;
      valid_q <= '0;
    end else begin
      case (state_q)
        SL_FREE: if (alloc_i) begin
          state_q <= SL_FILL;
          cnt_q   <= '0;
          line_q  <= alloc_line_i;
          valid_q <= '0;
        end
        SL_FILL: begin
          valid_q <= valid_q | core_b | fill_b;
          if (beat_i) begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(BEATS - 1)) state_q <= SL_FULL;
          end
        end
        SL_FULL: if (release_i) state_q <= SL_FREE;
        default: state_q <= SL_FREE;
      endcase
    end
  end

  assign state_o = state_q;
  assign line_o  = line_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;

  a_r2_beat_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> state_q == SL_FILL);
  a_r3_full_all_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SL_FULL |-> &valid_q);
  a_r5_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SL_FILL && $past(state_q) == SL_FILL) |-> ((valid_q & $past(valid_q)) == $past(valid_q)));
  a_r8_full_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SL_FULL && $past(state_q) == SL_FULL) |-> $stable(data_q));
  a_r4_release_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> state_q == SL_FULL);
endmodule

// File: rtl/lcb_wb_sel.sv
module lcb_wb_sel #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  full_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic          locked_q, pick_v;
  logic [IW-1:0] lidx_q, pick_i;

  always_comb begin
    pick_v = 1'b0;
    pick_i = '0;
    for (int i = 0; i < N; i++) begin
      if (!pick_v && full_i[i]) begin
        pick_v = 1'b1;
        pick_i = IW'(i);
      end
    end
  end

  // hold the offered slot until the cache takes it
  assign valid_o = locked_q || pick_v;
  assign idx_o   = locked_q ? lidx_q : pick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      lidx_q   <= '0;
    end else begin
      locked_q <= valid_o && !ready_i;
      if (valid_o && !ready_i) lidx_q <= idx_o;
    end
  end

  a_r4_offer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && idx_o == $past(idx_o)));
endmodule

// File: rtl/line_build_buf.sv
module line_build_buf import lcb_pkg::*; #(
  parameter int LINE_W = 256,
  parameter int BEAT_W = 64,
  parameter int CORE_W = 64,
  parameter int LA_W   = 27,
  parameter int SLOTS  = 4,
  localparam int SI_W   = $clog2(SLOTS),
  localparam int WORDS  = LINE_W / CORE_W,
  localparam int WI_W   = $clog2(WORDS),
  localparam int CORE_B = CORE_W / 8,
  localparam int LINE_B = LINE_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_req_i,
  input  logic [LA_W-1:0]   fill_line_i,
  output logic              fill_gnt_o,
  output logic [SI_W-1:0]   fill_slot_o,
  input  logic              mem_valid_i,
  input  logic              mem_nc_i,
  input  logic [SI_W-1:0]   mem_slot_i,
  input  logic [BEAT_W-1:0] mem_data_i,
  output logic              nc_valid_o,
  output logic [BEAT_W-1:0] nc_data_o,
  input  logic              core_req_i,
  input  logic              core_we_i,
  input  logic [LA_W-1:0]   core_line_i,
  input  logic [WI_W-1:0]   core_word_i,
  input  logic [CORE_B-1:0] core_be_i,
  input  logic [CORE_W-1:0] core_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [CORE_W-1:0] rsp_rdata_o,
  output logic              cw_valid_o,
  input  logic              cw_ready_i,
  output logic [LA_W-1:0]   cw_line_o,
  output logic [LINE_W-1:0] cw_data_o
);
  slot_state_e        s_state [SLOTS];
  logic [LA_W-1:0]    s_line  [SLOTS];
  logic [LINE_W-1:0]  s_data  [SLOTS];
  logic [LINE_B-1:0]  s_valid [SLOTS];
  logic [SLOTS-1:0]   free_v, full_v, alloc_v, beat_v, wr_v, rel_v;
  logic [SI_W-1:0]    alloc_idx, wb_idx, hit_idx;
  logic               hit_any, wr_ok, rd_hit;
  logic [LINE_B-1:0]  cwr_mask;
  logic [LINE_W-1:0]  cwr_data;
  logic [CORE_W-1:0]  rd_word, be_bits;
  logic [CORE_B-1:0]  rd_vbytes;

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!hit_any && s_state[i] != SL_FREE && s_line[i] == core_line_i) begin
        hit_any = 1'b1;
        hit_idx = SI_W'(i);
      end
    end
  end

  assign cwr_mask  = LINE_B'(core_be_i) << (CORE_B * int'(core_word_i));
  assign cwr_data  = {WORDS{core_wdata_i}};
  assign rd_word   = s_data[hit_idx][int'(core_word_i)*CORE_W +: CORE_W];
  assign rd_vbytes = s_valid[hit_idx][int'(core_word_i)*CORE_B +: CORE_B];

  for (genvar b = 0; b < CORE_B; b++) begin : g_be
    assign be_bits[b*8 +: 8] = {8{core_be_i[b]}};
  end

  assign wr_ok  = core_req_i && core_we_i && hit_any && s_state[hit_idx] == SL_FILL;
  assign rd_hit = core_req_i && !core_we_i && hit_any && ((rd_vbytes & core_be_i) == core_be_i);

  lcb_alloc #(.N(SLOTS), .IW(SI_W)) u_alloc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .free_i (free_v),
    .req_i  (fill_req_i),
    .gnt_o  (fill_gnt_o),
    .idx_o  (alloc_idx)
  );
  assign fill_slot_o = alloc_idx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign free_v[g]  = s_state[g] == SL_FREE;
    assign full_v[g]  = s_state[g] == SL_FULL;
    assign alloc_v[g] = fill_gnt_o && alloc_idx == SI_W'(g);
    assign beat_v[g]  = mem_valid_i && !mem_nc_i && mem_slot_i == SI_W'(g);
    assign wr_v[g]    = wr_ok && hit_idx == SI_W'(g);
    assign rel_v[g]   = cw_valid_o && cw_ready_i && wb_idx == SI_W'(g);

    lcb_slot #(.LINE_W(LINE_W), .BEAT_W(BEAT_W), .LA_W(LA_W)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc_v[g]),
      .alloc_line_i (fill_line_i),
      .beat_i       (beat_v[g]),
      .beat_data_i  (mem_data_i),
      .cwr_i        (wr_v[g]),
      .cwr_mask_i   (cwr_mask),
      .cwr_data_i   (cwr_data),
      .release_i    (rel_v[g]),
      .state_o      (s_state[g]),
      .line_o       (s_line[g]),
      .data_o       (s_data[g]),
      .valid_o      (s_valid[g])
    );
  end

  lcb_wb_sel #(.N(SLOTS), .IW(SI_W)) u_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .full_i  (full_v),
    .ready_i (cw_ready_i),
    .valid_o (cw_valid_o),
    .idx_o   (wb_idx)
  );
  assign cw_line_o = s_line[wb_idx];
  assign cw_data_o = s_data[wb_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_rdata_o <= '0;
      nc_valid_o  <= 1'b0;
      nc_data_o   <= '0;
    end else begin
      rsp_valid_o <= core_req_i;
      rsp_hit_o   <= wr_ok || rd_hit;
      rsp_rdata_o <= rd_hit ? (rd_word & be_bits) : '0;
      nc_valid_o  <= mem_valid_i && mem_nc_i;
      if (mem_valid_i && mem_nc_i) nc_data_o <= mem_data_i;
    end
  end

  a_r3_offer_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_valid_o |-> s_state[wb_idx] == SL_FULL);
  a_r9_nc_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && mem_nc_i) |=> (nc_valid_o && nc_data_o == $past(mem_data_i)));
  a_r9_nc_no_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && mem_nc_i) |-> beat_v == '0);
  a_r7_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> rsp_rdata_o == '0);
endmodule

// File: tb/line_build_buf_test.sv
module line_build_buf_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         fill_req_i, mem_valid_i, mem_nc_i, core_req_i, core_we_i, cw_ready_i;
  logic [26:0]  fill_line_i, core_line_i;
  logic [1:0]   mem_slot_i, core_word_i;
  logic [63:0]  mem_data_i, core_wdata_i;
  logic [7:0]   core_be_i;
  logic         fill_gnt_o, nc_valid_o, rsp_valid_o, rsp_hit_o, cw_valid_o;
  logic [1:0]   fill_slot_o;
  logic [63:0]  nc_data_o, rsp_rdata_o;
  logic [26:0]  cw_line_o;
  logic [255:0] cw_data_o;

  always #2 clk_i = ~clk_i;

  line_build_buf uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model of the slots
  bit           m_busy [4];
  logic [26:0]  m_line [4];
  logic [255:0] m_data [4];
  logic [31:0]  m_val  [4];
  int           m_cnt  [4];
  int           m_rr = 0;
  bit           m_lock = 1'b0;
  int           m_lidx = 0;
  bit           e_rv, e_hit, e_ncv;
  logic [63:0]  e_rd, e_ncd;
  string        e_tag;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    fill_req_i = 0; fill_line_i = '0; mem_valid_i = 0; mem_nc_i = 0; mem_slot_i = '0;
    mem_data_i = '0; core_req_i = 0; core_we_i = 0; core_line_i = '0; core_word_i = '0;
    core_be_i = '0; core_wdata_i = '0; cw_ready_i = 0;
  endtask

  function automatic int find_line(input logic [26:0] ln);
    for (int i = 0; i < 4; i++) if (m_busy[i] && m_line[i] == ln) return i;
    return -1;
  endfunction

  task automatic cyc();
    int g_slot, wb, hs, s;
    bit g_ok, wb_ok, wr;
    logic [31:0] cmask, bmask;
    logic [63:0] w;
    #1;
    // expected combinational outputs
    g_ok = 0; g_slot = 0;
    for (int k = 0; k < 4; k++) begin
      s = (m_rr + k) % 4;
      if (!g_ok && !m_busy[s]) begin g_ok = 1; g_slot = s; end
    end
    g_ok = g_ok && fill_req_i;
    chk(fill_gnt_o == g_ok, "R1 grant", 256'(fill_gnt_o), 256'(g_ok));
    if (g_ok) chk(fill_slot_o == 2'(g_slot), "R1 slot", 256'(fill_slot_o), 256'(g_slot));
    wb_ok = 0; wb = 0;
    if (m_lock) begin wb_ok = 1; wb = m_lidx; end
    else for (int i = 0; i < 4; i++) if (!wb_ok && m_busy[i] && m_cnt[i] == 4) begin wb_ok = 1; wb = i; end
    chk(cw_valid_o == wb_ok, "R3 offer", 256'(cw_valid_o), 256'(wb_ok));
    if (wb_ok) begin
      chk(cw_line_o == m_line[wb], m_lock ? "R4 line held" : "R3 line", 256'(cw_line_o), 256'(m_line[wb]));
      chk(cw_data_o == m_data[wb], m_lock ? "R4 data held" : "R3 data", cw_data_o, m_data[wb]);
    end
    // expected response
    e_rv = core_req_i; e_hit = 0; e_rd = '0; wr = 0; cmask = '0;
    hs = find_line(core_line_i);
    if (core_req_i && core_we_i) begin
      e_tag = "R8 write";
      if (hs >= 0 && m_cnt[hs] < 4) begin
        e_hit = 1; wr = 1; e_tag = "R5 write";
        cmask = 32'(core_be_i) << (8 * core_word_i);
      end
    end else if (core_req_i) begin
      e_tag = "R7 read";
      if (hs >= 0 && ((m_val[hs][core_word_i*8 +: 8] & core_be_i) == core_be_i)) begin
        e_hit = 1; e_tag = "R6 read";
        w = m_data[hs][core_word_i*64 +: 64];
        for (int b = 0; b < 8; b++) if (core_be_i[b]) e_rd[b*8 +: 8] = w[b*8 +: 8];
      end
    end
    e_ncv = mem_valid_i && mem_nc_i; e_ncd = mem_data_i;
    // next state from pre-edge state
    if (wr) begin
      for (int b = 0; b < 32; b++) if (cmask[b]) m_data[hs][b*8 +: 8] = core_wdata_i[(b%8)*8 +: 8];
    end
    if (mem_valid_i && !mem_nc_i) begin
      s = int'(mem_slot_i);
      bmask = (32'hFF << (8 * m_cnt[s])) & ~m_val[s] & ~((wr && hs == s) ? cmask : 32'h0);
      for (int b = 0; b < 32; b++) if (bmask[b]) m_data[s][b*8 +: 8] = mem_data_i[(b%8)*8 +: 8];
      m_val[s] = m_val[s] | bmask;
      m_cnt[s]++;
    end
    if (wr) m_val[hs] = m_val[hs] | cmask;
    if (wb_ok && cw_ready_i) m_busy[wb] = 0;
    m_lock = wb_ok && !cw_ready_i; m_lidx = wb;
    if (g_ok) begin
      m_busy[g_slot] = 1; m_line[g_slot] = fill_line_i; m_cnt[g_slot] = 0; m_val[g_slot] = '0;
      m_rr = (g_slot + 1) % 4;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(rsp_valid_o == e_rv, "R6 rsp_valid", 256'(rsp_valid_o), 256'(e_rv));
    if (e_rv) begin
      chk(rsp_hit_o == e_hit, e_tag, 256'(rsp_hit_o), 256'(e_hit));
      chk(rsp_rdata_o == e_rd, e_tag, 256'(rsp_rdata_o), 256'(e_rd));
    end
    chk(nc_valid_o == e_ncv, "R9 nc_valid", 256'(nc_valid_o), 256'(e_ncv));
    if (e_ncv) chk(nc_data_o == e_ncd, "R9 nc_data", 256'(nc_data_o), 256'(e_ncd));
  endtask

  localparam logic [26:0] BASE = 27'h0123400;
  localparam logic [63:0] DA = 64'hAAAA_AAAA_A1A2_A3A4, DC = 64'hC1C2_C3C4_CCCC_CCCC;
  localparam logic [63:0] B0 = 64'h1010_1111_1212_1313, B1 = 64'h2020_2121_2222_2323;
  localparam logic [63:0] B2 = 64'h3030_3131_3232_3333, B3 = 64'h4040_4141_4242_4343;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cand [4];
    int nc, next_line;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin m_busy[i] = 0; m_cnt[i] = 0; m_val[i] = '0; m_data[i] = '0; m_line[i] = '0; end
    idle();
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(cw_valid_o == 0 && rsp_valid_o == 0 && nc_valid_o == 0 && fill_gnt_o == 0, "R10 reset",
        {cw_valid_o, rsp_valid_o, nc_valid_o, fill_gnt_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: four grants in order, fifth stalls
    for (int i = 0; i < 5; i++) begin idle(); fill_req_i = 1; fill_line_i = BASE + 27'(i); cyc(); end
    // R7: read before any chunk
    idle(); core_req_i = 1; core_line_i = BASE; core_word_i = 0; core_be_i = 8'hFF; cyc();
    chk(rsp_hit_o == 0, "R7 early read", 256'(rsp_hit_o), 256'(0));
    // R5: store into word 1 low half
    idle(); core_req_i = 1; core_we_i = 1; core_line_i = BASE; core_word_i = 1; core_be_i = 8'h0F; core_wdata_i = DA; cyc();
    // R5: store and chunk 0 on the same word in the same cycle
    idle(); mem_valid_i = 1; mem_slot_i = 0; mem_data_i = B0;
    core_req_i = 1; core_we_i = 1; core_line_i = BASE; core_word_i = 0; core_be_i = 8'hF0; core_wdata_i = DC; cyc();
    idle(); mem_valid_i = 1; mem_slot_i = 0; mem_data_i = B1; cyc();
    idle(); mem_valid_i = 1; mem_slot_i = 0; mem_data_i = B2; cyc();
    idle(); mem_valid_i = 1; mem_slot_i = 0; mem_data_i = B3; cyc();
    idle(); cyc();
    chk(cw_valid_o == 1, "R4 offer waits", 256'(cw_valid_o), 256'(1));
    idle(); core_req_i = 1; core_line_i = BASE; core_word_i = 2; core_be_i = 8'hFF; cyc();
    chk(rsp_rdata_o == B2, "R2 chunk order", 256'(rsp_rdata_o), 256'(B2));
    idle(); core_req_i = 1; core_line_i = BASE; core_word_i = 1; core_be_i = 8'hFF; cyc();
    chk(rsp_rdata_o == {B1[63:32], DA[31:0]}, "R5 store kept", 256'(rsp_rdata_o), 256'({B1[63:32], DA[31:0]}));
    idle(); core_req_i = 1; core_line_i = BASE; core_word_i = 0; core_be_i = 8'hFF; cyc();
    chk(rsp_rdata_o == {DC[63:32], B0[31:0]}, "R5 same cycle", 256'(rsp_rdata_o), 256'({DC[63:32], B0[31:0]}));
    // R8: write to a complete slot
    idle(); core_req_i = 1; core_we_i = 1; core_line_i = BASE; core_word_i = 3; core_be_i = 8'hFF; core_wdata_i = '1; cyc();
    chk(rsp_hit_o == 0, "R8 refused", 256'(rsp_hit_o), 256'(0));
    idle(); cw_ready_i = 1; cyc();
    // R4: slot 0 reused
    idle(); fill_req_i = 1; fill_line_i = BASE + 27'd10; #1;
    chk(fill_gnt_o == 1 && fill_slot_o == 2'd0, "R4 reuse", 256'({fill_gnt_o, fill_slot_o}), 256'({1'b1, 2'd0}));
    cyc();
    // R9: non-cacheable chunk
    idle(); mem_valid_i = 1; mem_nc_i = 1; mem_slot_i = 1; mem_data_i = 64'hDEAD_BEEF_0BAD_F00D; cyc();
    chk(nc_valid_o == 1 && nc_data_o == 64'hDEAD_BEEF_0BAD_F00D, "R9 forward", 256'(nc_data_o), 256'(64'hDEAD_BEEF_0BAD_F00D));

    // random phase
    next_line = 100;
    for (int it = 0; it < 800; it++) begin
      idle();
      if ($urandom % 3 == 0) begin fill_req_i = 1; fill_line_i = 27'(next_line); next_line++; end
      nc = 0;
      for (int i = 0; i < 4; i++) if (m_busy[i] && m_cnt[i] < 4) begin cand[nc] = i; nc++; end
      if (nc > 0 && $urandom % 2 == 0) begin
        mem_valid_i = 1; mem_slot_i = 2'(cand[$urandom % nc]); mem_data_i = {$urandom, $urandom};
      end else if ($urandom % 8 == 0) begin
        mem_valid_i = 1; mem_nc_i = 1; mem_slot_i = 2'($urandom); mem_data_i = {$urandom, $urandom};
      end
      if ($urandom % 2 == 0) begin
        core_req_i = 1; core_we_i = 1'($urandom); core_word_i = 2'($urandom);
        core_be_i = 8'($urandom % 255 + 1); core_wdata_i = {$urandom, $urandom};
        core_line_i = 27'h7FFFFFF;
        if ($urandom % 5 != 0) begin
          int s = int'($urandom % 4);
          if (m_busy[s]) core_line_i = m_line[s];
        end
      end
      cw_ready_i = 1'($urandom);
      cyc();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule